// File: doc/BRIEF.md
# Clock Source Loss Qualifier

This block sits between a per-source loss-of-signal detector and the clock selector. It takes the raw loss flag for one candidate clock source and produces a qualified availability flag. A short glitch in the raw flag does not disturb the selector. A source that has really failed only becomes usable again after it has stayed clean for a set time. One copy is built per source.

A loss first enters a hold-off window. If the raw flag clears before the window expires, the source is treated as if nothing happened. If the window runs out, the source is declared lost. When the signal returns, a wait-to-restore (WTR) window starts, and the source stays unusable until that window ends. Software can cut the window short with a one-cycle clear pulse. Both windows are counted in millisecond ticks supplied from outside, against run-time limit inputs. The counter saturates and never wraps.

The controller has four states. AVAIL means the source is usable. HOLD means a raw loss is pending inside the hold-off window. LOST means the loss has been qualified. WTR means the signal is back but still waiting. The named transitions are:
- loss-seen (AVAIL to HOLD)
- loss-now (AVAIL to LOST, when the hold-off limit is zero)
- glitch-gone (HOLD to AVAIL)
- hold-expire (HOLD to LOST)
- signal-back (LOST to WTR)
- back-now (LOST to AVAIL, when the WTR limit is zero)
- relapse (WTR to LOST)
- wtr-clear (WTR to AVAIL)
- wtr-expire (WTR to AVAIL)

The outputs are decoded from the state: AVAIL and HOLD drive the available flag, LOST drives the loss status, and WTR drives the WTR-active status.

Top module: `clksrc_loss_qual`

## Requirements
- R1: After reset the outputs are available=1, loss status=0 and WTR-active=0.
- R2: With a hold-off limit N>0, a raw loss enters HOLD on the next edge, and the outputs stay available=1, loss=0 until the N-th tick seen in HOLD. On the edge that samples that tick the state becomes LOST (available=0, loss=1). Cycles without a tick do not advance the count.
- R3: If the raw loss clears while in HOLD, the next state is AVAIL, and available stays 1 throughout. This holds even when the clearing coincides with the expiring tick. A later loss restarts the hold-off count from zero.
- R4: With a hold-off limit of zero, a raw loss sampled in AVAIL gives loss=1, available=0 after one edge.
- R5: When the raw loss clears in LOST and the WTR limit M>0, the next state is WTR (available=0, loss=0, WTR-active=1). The state becomes AVAIL on the edge that samples the M-th tick seen in WTR.
- R6: When the raw loss clears in LOST and the WTR limit is zero, the next state is AVAIL.
- R7: A clear pulse sampled in WTR, without a raw loss, makes the next state AVAIL. A clear pulse in AVAIL, HOLD or LOST changes no output and no pending count.
- R8: A raw loss sampled in WTR moves straight to LOST. On the following return the WTR count starts again from zero.
- R9: When a raw loss and a clear pulse are sampled together in WTR, the loss wins and the next state is LOST.
- R10: A limit of all ones (2^TW-1) takes exactly that many ticks, because the counter is TW bits wide, saturates and does not wrap.
- R11: At most one of the three status conditions holds at any time: available, loss, WTR-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sig_lost_i | input | 1 | Raw loss-of-signal flag from the detector |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| holdoff_ms_i | input | TW | Hold-off limit in ticks |
| wtr_ms_i | input | TW | Wait-to-restore limit in ticks |
| clr_wtr_i | input | 1 | One-cycle command that ends WTR at once |
| src_avail_o | output | 1 | Qualified availability for the selector |
| locs_o | output | 1 | Qualified loss status |
| wtr_busy_o | output | 1 | WTR window active |

## Verification
The bench builds the block with TW=6, so a limit of all ones is only 63 ticks. This brings the saturating-limit case of R10 within a few hundred cycles, for both the hold-off and the WTR window. The small limits of 3 and 4 ticks used elsewhere let every transition be checked cycle by cycle, including cases where an event coincides with the expiring tick.

// File: rtl/clq_pkg.sv
package clq_pkg;
    typedef enum logic [1:0] {
        ST_AVAIL = 2'd0,
        ST_HOLD  = 2'd1,
        ST_LOST  = 2'd2,
        ST_WTR   = 2'd3
    } clq_state_e;
endpackage

// File: rtl/clq_timer.sv
// Saturating tick counter; reports expiry against a run-time limit.
module clq_timer #(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          restart_i,
    input  logic          tick_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};

    always_ff @(posedge clk_i) begin
        if (!rst_ni || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expires on the tick that brings the count up to the limit.
    always_comb begin
        expire_o = 1'b0;
        if (limit_i == '0) begin
            expire_o = 1'b1;
        end else if (tick_i && (cnt_inc >= {1'b0, limit_i})) begin
            expire_o = 1'b1;
        end
    end
endmodule

// File: rtl/clq_fsm.sv
// Qualification state machine.
module clq_fsm
    import clq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lost_i,
    input  logic       clear_i,
    input  logic       ho_zero_i,
    input  logic       wtr_zero_i,
    input  logic       expire_i,
    output clq_state_e state_o,
    output logic       restart_o,
    output logic       avail_o,
    output logic       locs_o,
    output logic       wtr_o
);
    clq_state_e state_q;
    clq_state_e state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_AVAIL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AVAIL: begin
                if (lost_i) begin
                    state_d = ho_zero_i ? ST_LOST : ST_HOLD;  // loss-now / loss-seen
                end
            end
            ST_HOLD: begin
                if (!lost_i) begin
                    state_d = ST_AVAIL;                      // glitch-gone
                end else if (expire_i) begin
                    state_d = ST_LOST;                       // hold-expire
                end
            end
            ST_LOST: begin
                if (!lost_i) begin
                    state_d = wtr_zero_i ? ST_AVAIL : ST_WTR; // back-now / signal-back
                end
            end
            ST_WTR: begin
                if (lost_i) begin
                    state_d = ST_LOST;                       // relapse
                end else if (clear_i || expire_i) begin
                    state_d = ST_AVAIL;                      // wtr-clear / wtr-expire
                end
            end
            default: state_d = ST_AVAIL;
        endcase
    end

    always_comb begin
        avail_o   = 1'b0;
        locs_o    = 1'b0;
        wtr_o     = 1'b0;
        unique case (state_q)
            ST_AVAIL, ST_HOLD: avail_o = 1'b1;
            ST_LOST:           locs_o  = 1'b1;
            ST_WTR:            wtr_o   = 1'b1;
            default:           avail_o = 1'b0;
        endcase
    end

    assign restart_o = (state_d != state_q);
    assign state_o   = state_q;
endmodule

// File: rtl/clksrc_loss_qual.sv
module clksrc_loss_qual
    import clq_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sig_lost_i,
    input  logic          ms_tick_i,
    input  logic [TW-1:0] holdoff_ms_i,
    input  logic [TW-1:0] wtr_ms_i,
    input  logic          clr_wtr_i,
    output logic          src_avail_o,
    output logic          locs_o,
    output logic          wtr_busy_o
);
    clq_state_e    state;
    logic          restart;
    logic          expire;
    logic [TW-1:0] limit;

    // The window limit follows the state that is counting.
    assign limit = (state == ST_WTR) ? wtr_ms_i : holdoff_ms_i;

    clq_timer #(.TW(TW)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .tick_i    (ms_tick_i),
        .limit_i   (limit),
        .expire_o  (expire)
    );

    clq_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lost_i     (sig_lost_i),
        .clear_i    (clr_wtr_i),
        .ho_zero_i  (holdoff_ms_i == '0),
        .wtr_zero_i (wtr_ms_i == '0),
        .expire_i   (expire),
        .state_o    (state),
        .restart_o  (restart),
        .avail_o    (src_avail_o),
        .locs_o     (locs_o),
        .wtr_o      (wtr_busy_o)
    );
endmodule

// File: rtl/clq_checker.sv
module clq_checker #(
    parameter int TW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          sig_lost_i,
    input logic          clr_wtr_i,
    input logic [TW-1:0] holdoff_ms_i,
    input logic [TW-1:0] wtr_ms_i,
    input logic          src_avail_o,
    input logic          locs_o,
    input logic          wtr_busy_o
);
    a_r11_one_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({src_avail_o, locs_o, wtr_busy_o}) == 1);

    a_r3_recovery_keeps_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_avail_o && !sig_lost_i) |=> src_avail_o);

    a_r2_loss_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locs_o) |-> $past(sig_lost_i));

    a_r5_enter_wtr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locs_o && !sig_lost_i && (wtr_ms_i != '0)) |=> wtr_busy_o);

    a_r6_zero_wtr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locs_o && !sig_lost_i && (wtr_ms_i == '0)) |=> src_avail_o);

    a_r7_clear_ends_wtr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wtr_busy_o && clr_wtr_i && !sig_lost_i) |=> src_avail_o);

    a_r8_relapse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wtr_busy_o && sig_lost_i) |=> locs_o);

    a_r4_zero_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_avail_o && sig_lost_i && (holdoff_ms_i == '0)) |=> locs_o);
endmodule

bind clksrc_loss_qual clq_checker #(.TW(TW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sig_lost_i   (sig_lost_i),
    .clr_wtr_i    (clr_wtr_i),
    .holdoff_ms_i (holdoff_ms_i),
    .wtr_ms_i     (wtr_ms_i),
    .src_avail_o  (src_avail_o),
    .locs_o       (locs_o),
    .wtr_busy_o   (wtr_busy_o)
);

// File: tb/sim_clksrc_loss_qual.sv
`timescale 1ns/1ps
module sim_clksrc_loss_qual;
    localparam int TW = 6;

    typedef struct {
        logic  av;
        logic  ls;
        logic  wb;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lost = 1'b0;
    logic          tick = 1'b0;
    logic [TW-1:0] ho = 6'd3;
    logic [TW-1:0] wtr = 6'd4;
    logic          clr = 1'b0;
    logic          av, ls, wb;

    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    clksrc_loss_qual #(.TW(TW)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sig_lost_i   (lost),
        .ms_tick_i    (tick),
        .holdoff_ms_i (ho),
        .wtr_ms_i     (wtr),
        .clr_wtr_i    (clr),
        .src_avail_o  (av),
        .locs_o       (ls),
        .wtr_busy_o   (wb)
    );

    // Driver side: queue the outputs expected in the current cycle.
    task automatic chk(input logic a, input logic l, input logic w, input string tag);
        exp_t e;
        e.av = a; e.ls = l; e.wb = w; e.tag = tag;
        q.push_back(e);
    endtask

    // n tick pulses; the outputs before each consumed tick are checked.
    task automatic pulses(input int n, input logic a, input logic l, input logic w,
                          input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            chk(a, l, w, tag);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Monitor: compare every queued item shortly after the falling edge.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if ({av, ls, wb} !== {e.av, e.ls, e.wb}) begin
                n_fail++;
                $display("FAIL %s: got avail/locs/wtr=%b%b%b expected %b%b%b",
                         e.tag, av, ls, wb, e.av, e.ls, e.wb);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, 0, 0, "R1 reset state");

        // R2: hold-off of 3 ticks, with idle cycles between them
        lost = 1'b1;
        @(negedge clk);
        chk(1, 0, 0, "R2 in hold-off");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            tick = 1'b0;
            chk(1, 0, 0, "R2 before tick");
            @(negedge clk);
            chk(1, 0, 0, "R2 idle cycle");
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
        chk(0, 1, 0, "R2 hold-off expired");

        // R7: clear in LOST ignored
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(0, 1, 0, "R7 clear ignored in lost");

        // R5: return, WTR of 4 ticks
        lost = 1'b0;
        @(negedge clk);
        chk(0, 0, 1, "R5 enter wtr");
        pulses(4, 0, 0, 1, "R5 waiting");
        chk(1, 0, 0, "R5 wtr expired");

        // R7: clear in AVAIL ignored
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(1, 0, 0, "R7 clear ignored in avail");

        // R3: glitch shorter than hold-off, then full restart
        lost = 1'b1;
        pulses(2, 1, 0, 0, "R3 glitch");
        lost = 1'b0;
        chk(1, 0, 0, "R3 glitch");
        @(negedge clk);
        chk(1, 0, 0, "R3 back to avail");
        lost = 1'b1;
        @(negedge clk);
        chk(1, 0, 0, "R3 new hold-off");
        pulses(2, 1, 0, 0, "R3 new hold-off");
        chk(1, 0, 0, "R3 count restarted");
        pulses(1, 1, 0, 0, "R3 new hold-off");
        chk(0, 1, 0, "R3 expired after full window");

        // R8: relapse inside WTR restarts the count
        lost = 1'b0;
        @(negedge clk);
        chk(0, 0, 1, "R8 enter wtr");
        pulses(3, 0, 0, 1, "R8 partial wtr");
        lost = 1'b1;
        @(negedge clk);
        chk(0, 1, 0, "R8 relapse to lost");
        lost = 1'b0;
        @(negedge clk);
        chk(0, 0, 1, "R8 wtr again");
        pulses(3, 0, 0, 1, "R8 wtr again");
        chk(0, 0, 1, "R8 wtr count restarted");
        pulses(1, 0, 0, 1, "R8 wtr again");
        chk(1, 0, 0, "R8 wtr expired");

        // R3: recovery coinciding with the expiring tick
        ho = 6'd1;
        lost = 1'b1;
        @(negedge clk);
        chk(1, 0, 0, "R3 hold-off 1");
        tick = 1'b1;
        lost = 1'b0;
        @(negedge clk);
        tick = 1'b0;
        chk(1, 0, 0, "R3 recovery beats expiry");
        @(negedge clk);
        chk(1, 0, 0, "R3 recovery beats expiry");

        // R4: zero hold-off
        ho = 6'd0;
        lost = 1'b1;
        @(negedge clk);
        chk(0, 1, 0, "R4 immediate loss");

        // R9: loss and clear together in WTR
        lost = 1'b0;
        @(negedge clk);
        chk(0, 0, 1, "R9 enter wtr");
        lost = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(0, 1, 0, "R9 loss wins over clear");

        // R7: clear ends WTR
        lost = 1'b0;
        @(negedge clk);
        chk(0, 0, 1, "R7 enter wtr");
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(1, 0, 0, "R7 clear ends wtr");

        // R7: clear in HOLD has no effect on the pending count
        ho = 6'd2;
        lost = 1'b1;
        @(negedge clk);
        chk(1, 0, 0, "R7 hold-off");
        pulses(1, 1, 0, 0, "R7 hold-off");
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(1, 0, 0, "R7 clear ignored in hold-off");
        pulses(1, 1, 0, 0, "R7 hold-off");
        chk(0, 1, 0, "R7 hold-off count kept");

        // R6: zero WTR
        wtr = 6'd0;
        lost = 1'b0;
        @(negedge clk);
        chk(1, 0, 0, "R6 immediate restore");

        // R10: all-ones limits
        ho = 6'd63;
        wtr = 6'd63;
        lost = 1'b1;
        @(negedge clk);
        chk(1, 0, 0, "R10 max hold-off");
        pulses(62, 1, 0, 0, "R10 max hold-off");
        chk(1, 0, 0, "R10 one tick short");
        pulses(1, 1, 0, 0, "R10 max hold-off");
        chk(0, 1, 0, "R10 hold-off expired");
        lost = 1'b0;
        @(negedge clk);
        chk(0, 0, 1, "R10 max wtr");
        pulses(62, 0, 0, 1, "R10 max wtr");
        chk(0, 0, 1, "R10 wtr one tick short");
        pulses(1, 0, 0, 1, "R10 max wtr");
        chk(1, 0, 0, "R10 wtr expired");

        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule